// File: doc/BRIEF.md
# Vector Integer Reduction Unit

This unit reduces one vector register operand to a single scalar. A 32-bit instruction word selects one of eight combining operations: wrapping sum, bitwise and, bitwise or, bitwise xor, unsigned minimum, signed minimum, unsigned maximum and signed maximum. The running value starts as element 0 of the first source register. The unit then combines it with the elements of the second source register one at a time, in index order, up to the active length. A mask register can make the unit skip elements.

The result goes into element 0 of a flat destination register, and every byte above that element is cleared. One pulse on `start` captures all operands. The unit then takes one clock per active element and raises `done` for one cycle when `vd_out` holds the new value. An instruction word that does not decode raises `illegal` together with `done`, and `vd_out` is left as it was.

Top module: `vred_unit`

## Requirements
- R1: The word is legal only when bits [6:0] = 1010111, bits [14:12] = 010 and bits [31:26] hold a value from 0 to 7. Otherwise, one cycle after the start edge, `done` and `illegal` are both high for that cycle and `vd_out` keeps its previous value.
- R2: The running value starts as element 0 of `vs1_in`. It is then combined with elements 0, 1, ... of `vs2_in`, in that order, below the effective length. Element i occupies bits [i*W +: W].
- R3: Bit 25 of the word is the mask enable, active low. When it is 0, element i is skipped whenever bit i of `v0_in` is 0. When it is 1, every element below the length is used. Mask bits at or above the length have no effect.
- R4: The result sits in the low W bits of `vd_out`, and all bits of `vd_out` above W are zero.
- R5: `ew_sel` selects the element width W: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64 bits. The seed, the elements and the result all use W.
- R6: bits [31:26] values 4 (unsigned min) and 6 (unsigned max) compare elements as unsigned numbers. Values 5 (signed min) and 7 (signed max) compare them as two's-complement numbers.
- R7: Value 0 (sum) adds modulo 2^W. Values 1, 2 and 3 give bitwise and, or and xor.
- R8: When the effective length is 0, or when every element is masked off, the result is the seed, and the bits above W are still cleared.
- R9: The effective length is the smaller of `vl` and VLEN/W.
- R10: For a legal word with effective length n, `done` is high for exactly one cycle, n+2 cycles after the start edge. `busy` is high between the start edge and `done`, and `start` has no effect while `busy` is high.
- R11: After reset, `busy`, `done` and `illegal` are low and `vd_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction; sampled only while idle |
| insn | input | 32 | Instruction word |
| ew_sel | input | 2 | Element width select |
| vl | input | $clog2(VLEN/8)+1 | Requested active length |
| vs1_in | input | VLEN | Register holding the seed in element 0 |
| vs2_in | input | VLEN | Register holding the elements to reduce |
| v0_in | input | VLEN | Mask register, one bit per element |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Decode failure, valid with done |
| vd_out | output | VLEN | Destination register value |

## Verification
The checker relies on the element width being stable in the cycle that `start` is accepted, because it records that width to check the cleared upper bits. It also assumes `start` is a synchronous, clean input. The bench changes inputs only on falling edges and holds `ew_sel` constant while each `start` is high. All operand values are captured on the start edge, and the bench drives unrelated values on them during a run to show that they are not reread.

// File: rtl/vred_pkg.sv
package vred_pkg;

  localparam logic [6:0] OPC_VRED = 7'b1010111;
  localparam logic [2:0] F3_VRED  = 3'b010;

  typedef enum logic [2:0] {
    OP_SUM  = 3'd0,
    OP_AND  = 3'd1,
    OP_OR   = 3'd2,
    OP_XOR  = 3'd3,
    OP_MINU = 3'd4,
    OP_MIN  = 3'd5,
    OP_MAXU = 3'd6,
    OP_MAX  = 3'd7
  } red_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } red_st_e;

  function automatic logic [63:0] width_mask(input logic [1:0] ew);
    case (ew)
      2'd0:    width_mask = 64'h0000_0000_0000_00FF;
      2'd1:    width_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    width_mask = 64'h0000_0000_FFFF_FFFF;
      default: width_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic [63:0] sign_ext(input logic [63:0] x, input logic [1:0] ew);
    case (ew)
      2'd0:    sign_ext = {{56{x[7]}},  x[7:0]};
      2'd1:    sign_ext = {{48{x[15]}}, x[15:0]};
      2'd2:    sign_ext = {{32{x[31]}}, x[31:0]};
      default: sign_ext = x;
    endcase
  endfunction

endpackage

// File: rtl/vred_rst_sync.sv
module vred_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vred_decode.sv
module vred_decode
  import vred_pkg::*;
(
  input  logic [31:0] insn,
  output logic        legal,
  output red_op_e     op,
  output logic        vm
);
  logic opc_ok;
  logic f3_ok;
  logic f6_ok;

  always_comb begin
    opc_ok = (insn[6:0] == OPC_VRED);
    f3_ok  = (insn[14:12] == F3_VRED);
    f6_ok  = (insn[31:29] == 3'b000);
    legal  = opc_ok && f3_ok && f6_ok;
    op     = red_op_e'(insn[28:26]);
    vm     = insn[25];
  end
endmodule

// File: rtl/vred_lane_pick.sv
module vred_lane_pick #(
  parameter int VLEN  = 128,
  parameter int IDX_W = 5
) (
  input  logic [VLEN-1:0]  src,
  input  logic [1:0]       ew,
  input  logic [IDX_W-1:0] idx,
  output logic [63:0]      elem
);
  for (genvar g = 0; g < 4; g++) begin : g_w
    localparam int EB = 8 << g;
    localparam int NE = VLEN / EB;
    logic [63:0] cand;
    always_comb begin
      cand = '0;
      if (int'(idx) < NE) cand[EB-1:0] = src[int'(idx)*EB +: EB];
    end
  end

  always_comb begin
    case (ew)
      2'd0:    elem = g_w[0].cand;
      2'd1:    elem = g_w[1].cand;
      2'd2:    elem = g_w[2].cand;
      default: elem = g_w[3].cand;
    endcase
  end
endmodule

// File: rtl/vred_alu.sv
module vred_alu
  import vred_pkg::*;
(
  input  red_op_e     op,
  input  logic [1:0]  ew,
  input  logic [63:0] acc,
  input  logic [63:0] elem,
  output logic [63:0] res
);
  logic [63:0] msk;
  logic [63:0] a_z;
  logic [63:0] e_z;
  logic [63:0] a_s;
  logic [63:0] e_s;
  logic        e_lt_u;
  logic        e_lt_s;
  logic [63:0] raw;

  always_comb begin
    msk    = width_mask(ew);
    a_z    = acc & msk;
    e_z    = elem & msk;
    a_s    = sign_ext(a_z, ew);
    e_s    = sign_ext(e_z, ew);
    e_lt_u = (e_z < a_z);
    e_lt_s = ($signed(e_s) < $signed(a_s));
    case (op)
      OP_SUM:  raw = a_z + e_z;
      OP_AND:  raw = a_z & e_z;
      OP_OR:   raw = a_z | e_z;
      OP_XOR:  raw = a_z ^ e_z;
      OP_MINU: raw = e_lt_u ? e_z : a_z;
      OP_MIN:  raw = e_lt_s ? e_z : a_z;
      OP_MAXU: raw = (!e_lt_u && e_z != a_z) ? e_z : a_z;
      default: raw = (!e_lt_s && e_s != a_s) ? e_z : a_z;
    endcase
    res = raw & msk;
  end
endmodule

// File: rtl/vred_unit.sv
module vred_unit
  import vred_pkg::*;
#(
  parameter  int VLEN = 128,
  localparam int VL_W = $clog2(VLEN / 8) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     insn,
  input  logic [1:0]      ew_sel,
  input  logic [VL_W-1:0] vl,
  input  logic [VLEN-1:0] vs1_in,
  input  logic [VLEN-1:0] vs2_in,
  input  logic [VLEN-1:0] v0_in,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [VLEN-1:0] vd_out
);
  localparam int MAXE  = VLEN / 8;
  localparam int MI_W  = $clog2(MAXE);

  logic            rst_i_n;
  red_st_e         st_q, st_d;
  logic [VL_W-1:0] idx_q, idx_d;
  logic [VL_W-1:0] lim_q, lim_d;
  logic [63:0]     acc_q, acc_d;
  red_op_e         op_q;
  logic            vm_q;
  logic [1:0]      ew_q;
  logic [VLEN-1:0] vs2_q;
  logic [MAXE-1:0] m_q;
  logic [VLEN-1:0] vd_q, vd_d;
  logic            done_q, done_d;
  logic            ill_q, ill_d;

  logic            dec_legal;
  red_op_e         dec_op;
  logic            dec_vm;
  logic [63:0]     seed;
  logic [63:0]     cur_elem;
  logic [63:0]     alu_res;
  logic [VL_W-1:0] max_el;
  logic [VL_W-1:0] lim_in;
  logic            ld_en;
  logic            vd_en;
  logic            mbit;

  vred_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  vred_decode u_dec (
    .insn  (insn),
    .legal (dec_legal),
    .op    (dec_op),
    .vm    (dec_vm)
  );

  vred_lane_pick #(.VLEN(VLEN), .IDX_W(VL_W)) u_seed (
    .src  (vs1_in),
    .ew   (ew_sel),
    .idx  ('0),
    .elem (seed)
  );

  vred_lane_pick #(.VLEN(VLEN), .IDX_W(VL_W)) u_elem (
    .src  (vs2_q),
    .ew   (ew_q),
    .idx  (idx_q),
    .elem (cur_elem)
  );

  vred_alu u_alu (
    .op   (op_q),
    .ew   (ew_q),
    .acc  (acc_q),
    .elem (cur_elem),
    .res  (alu_res)
  );

  always_comb begin
    max_el = VL_W'(MAXE >> ew_sel);
    lim_in = (vl > max_el) ? max_el : vl;
    mbit   = (int'(idx_q) < MAXE) ? m_q[idx_q[MI_W-1:0]] : 1'b0;
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    lim_d  = lim_q;
    acc_d  = acc_q;
    vd_d   = vd_q;
    done_d = 1'b0;
    ill_d  = 1'b0;
    ld_en  = 1'b0;
    vd_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (!dec_legal) begin
            done_d = 1'b1;
            ill_d  = 1'b1;
          end else begin
            ld_en = 1'b1;
            acc_d = seed;
            idx_d = '0;
            lim_d = lim_in;
            st_d  = ST_RUN;
          end
        end
      end
      default: begin
        if (idx_q == lim_q) begin
          vd_en  = 1'b1;
          vd_d   = VLEN'(acc_q);
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          if (vm_q || mbit) acc_d = alu_res;
          idx_d = idx_q + 1'b1;
        end
      end
    endcase
  end

  // control and accumulator registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lim_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      lim_q  <= lim_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end

  // operand capture, enabled on an accepted start
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q  <= OP_SUM;
      vm_q  <= 1'b1;
      ew_q  <= 2'd0;
      vs2_q <= '0;
      m_q   <= '0;
    end else if (ld_en) begin
      op_q  <= dec_op;
      vm_q  <= dec_vm;
      ew_q  <= ew_sel;
      vs2_q <= vs2_in;
      m_q   <= v0_in[MAXE-1:0];
    end
  end

  // destination register, enabled on completion
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   vd_q <= '0;
    else if (vd_en) vd_q <= vd_d;
  end

  assign busy    = (st_q == ST_RUN);
  assign done    = done_q;
  assign illegal = ill_q;
  assign vd_out  = vd_q;
endmodule

// File: rtl/vred_unit_chk.sv
module vred_unit_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [1:0]      ew_sel,
  input logic            busy,
  input logic            done,
  input logic            illegal,
  input logic [VLEN-1:0] vd_out
);
  logic [1:0] ew_cap;
  int         wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ew_cap <= 2'd0;
    else if (start && !busy) ew_cap <= ew_sel;
  end

  assign wbits = 8 << ew_cap;

  // R1
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R1
  illegal_keeps_vd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(vd_out));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> ((vd_out >> wbits) == '0));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  vd_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vd_out) |-> done);
endmodule

bind vred_unit vred_unit_chk #(.VLEN(VLEN)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .ew_sel  (ew_sel),
  .busy    (busy),
  .done    (done),
  .illegal (illegal),
  .vd_out  (vd_out)
);

// File: tb/vred_unit_tb_top.sv
module vred_unit_tb_top;
  localparam int VLEN = 128;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [31:0]  insn;
  logic [1:0]   ew_sel;
  logic [4:0]   vl;
  logic [127:0] vs1_in, vs2_in, v0_in;
  logic         busy, done, illegal;
  logic [127:0] vd_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  vred_unit #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .ew_sel(ew_sel),
    .vl(vl), .vs1_in(vs1_in), .vs2_in(vs2_in), .v0_in(v0_in),
    .busy(busy), .done(done), .illegal(illegal), .vd_out(vd_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [5:0]   f6;
    logic         vm;
    logic [1:0]   ew;
    logic [4:0]   vl;
    logic [127:0] s1;
    logic [127:0] s2;
    logic [127:0] m0;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TAB [NV] = '{
    // R2 R7 sum of bytes 1..16 plus seed
    '{6'd0, 1'b1, 2'd0, 5'd16, 128'h5, 128'h100F0E0D0C0B0A090807060504030201, 128'h0},
    // R7 byte sum wraps
    '{6'd0, 1'b1, 2'd0, 5'd16, 128'h10, {16{8'hFF}}, 128'h0},
    // R7 and over halfwords
    '{6'd1, 1'b1, 2'd1, 5'd8, 128'hFFFF, 128'hFFFFF0F0FFFFFF0FFFFFFFFFFFFFFFF3, 128'h0},
    // R3 or with mask 0101
    '{6'd2, 1'b0, 2'd2, 5'd4, 128'h100, 128'h00000008000000040000000200000001, 128'h5},
    // R7 xor over doublewords
    '{6'd3, 1'b1, 2'd3, 5'd2, 128'h0123456789ABCDEF, 128'hFFFF0000FFFF0000_00000000FFFFFFFF, 128'h0},
    // R6 unsigned byte min
    '{6'd4, 1'b1, 2'd0, 5'd16, 128'h7F, 128'h11223344556677880102030480C0F0E0, 128'h0},
    // R6 signed byte min
    '{6'd5, 1'b1, 2'd0, 5'd16, 128'h7F, 128'h11223344556677880102030480C0F0E0, 128'h0},
    // R6 unsigned halfword max
    '{6'd6, 1'b1, 2'd1, 5'd8, 128'h0001, 128'h0002_8000_7FFF_0003_FFFE_0010_0100_1000, 128'h0},
    // R6 signed halfword max
    '{6'd7, 1'b1, 2'd1, 5'd8, 128'hFF00, 128'hFFFF_8000_F000_8001_FFFE_C000_A000_9000, 128'h0},
    // R6 R5 signed doubleword min
    '{6'd5, 1'b1, 2'd3, 5'd2, 128'h10, 128'h8000000000000001_7FFFFFFFFFFFFFFF, 128'h0},
    // R9 word max, vl 9 clamps to 4
    '{6'd6, 1'b1, 2'd2, 5'd9, 128'h5, 128'h00000010_00000020_00000030_00000040, 128'h0},
    // R9 doubleword sum, vl 31 clamps to 2
    '{6'd0, 1'b1, 2'd3, 5'd31, 128'h1, 128'hFFFFFFFFFFFFFFFF_0000000000000002, 128'h0},
    // R8 R4 vl zero gives seed, upper seed bytes cleared
    '{6'd0, 1'b1, 2'd1, 5'd0, 128'hAAAA5555AAAA5555AAAA5555AAAABEEF, 128'h1234, 128'h0},
    // R8 all elements masked
    '{6'd7, 1'b0, 2'd2, 5'd4, 128'h00000003, 128'h7FFFFFFF7FFFFFFF7FFFFFFF7FFFFFFF, 128'h0},
    // R3 mask bits above vl ignored
    '{6'd0, 1'b0, 2'd0, 5'd4, 128'h0, 128'h0F0E0D0C0B0A09080706050403020100 + 128'h01010101, 128'hFFF5},
    // R3 vm set, mask contents ignored
    '{6'd0, 1'b1, 2'd0, 5'd4, 128'h0, 128'h0000000000000000000000000A0B0C0D, 128'h0}
  };

  function automatic longint sx(input logic [63:0] x, input int w);
    logic [63:0] t;
    t = x << (64 - w);
    return $signed(t) >>> (64 - w);
  endfunction

  function automatic logic [127:0] model(input logic [5:0] f6, input logic vm,
      input logic [1:0] ew, input int vlen_req, input logic [127:0] s1,
      input logic [127:0] s2, input logic [127:0] m0);
    int w;
    int n;
    int lim;
    logic [63:0] msk;
    logic [63:0] acc;
    logic [127:0] sh;
    logic [63:0] e;
    w   = 8 << ew;
    n   = 128 / w;
    lim = (vlen_req > n) ? n : vlen_req;
    msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    acc = s1[63:0] & msk;
    for (int i = 0; i < lim; i++) begin
      if (vm || m0[i]) begin
        sh = s2 >> (i * w);
        e  = sh[63:0] & msk;
        case (f6)
          6'd0: acc = (acc + e) & msk;
          6'd1: acc = acc & e;
          6'd2: acc = acc | e;
          6'd3: acc = acc ^ e;
          6'd4: if (e < acc) acc = e;
          6'd5: if (sx(e, w) < sx(acc, w)) acc = e;
          6'd6: if (e > acc) acc = e;
          default: if (sx(e, w) > sx(acc, w)) acc = e;
        endcase
      end
    end
    return {64'd0, acc};
  endfunction

  function automatic int eff_len(input logic [1:0] ew, input int v);
    int n;
    n = 16 >> ew;
    return (v > n) ? n : v;
  endfunction

  function automatic logic [31:0] mk_insn(input logic [5:0] f6, input logic vm);
    return {f6, vm, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1010111};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // issue one operation; returns the vd value, the illegal flag and the latency
  task automatic run(input logic [31:0] iw, input logic [1:0] ew, input logic [4:0] v,
      input logic [127:0] s1, input logic [127:0] s2, input logic [127:0] m0,
      output logic [127:0] res, output logic ill, output int lat);
    @(negedge clk);
    insn = iw; ew_sel = ew; vl = v; vs1_in = s1; vs2_in = s2; v0_in = m0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    vs1_in = ~s1; vs2_in = ~s2; v0_in = ~m0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    res = vd_out;
    ill = illegal;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [127:0] res;
    logic [127:0] keep;
    logic ill;
    int lat;
    vec_t t;
    start = 0; insn = '0; ew_sel = '0; vl = '0; vs1_in = '0; vs2_in = '0; v0_in = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 busy", 128'(busy), 128'd0);
    chk("R11 done", 128'(done), 128'd0);
    chk("R11 illegal", 128'(illegal), 128'd0);
    chk("R11 vd_out", vd_out, 128'd0);

    for (int k = 0; k < NV; k++) begin
      t = TAB[k];
      run(mk_insn(t.f6, t.vm), t.ew, t.vl, t.s1, t.s2, t.m0, res, ill, lat);
      chk($sformatf("R2 entry %0d result", k), res, model(t.f6, t.vm, t.ew, int'(t.vl), t.s1, t.s2, t.m0));
      chk($sformatf("R1 entry %0d no illegal", k), 128'(ill), 128'd0);
      chk($sformatf("R10 entry %0d latency", k), 128'(lat), 128'(eff_len(t.ew, int'(t.vl)) + 2));
      @(negedge clk);
      chk($sformatf("R10 entry %0d done single", k), 128'(done), 128'd0);
    end

    // R1 bad opcode, bad funct3, funct6 out of range: vd_out kept
    keep = vd_out;
    run(mk_insn(6'd0, 1'b1) ^ 32'h1, 2'd0, 5'd4, 128'h1, 128'h1, 128'h0, res, ill, lat);
    chk("R1 opcode illegal", 128'(ill), 128'd1);
    chk("R1 opcode latency", 128'(lat), 128'd1);
    chk("R1 opcode vd kept", res, keep);
    run(mk_insn(6'd0, 1'b1) ^ 32'h3000, 2'd0, 5'd4, 128'h1, 128'h1, 128'h0, res, ill, lat);
    chk("R1 funct3 illegal", 128'(ill), 128'd1);
    chk("R1 funct3 vd kept", res, keep);
    run(mk_insn(6'd8, 1'b1), 2'd0, 5'd4, 128'h1, 128'h1, 128'h0, res, ill, lat);
    chk("R1 funct6 illegal", 128'(ill), 128'd1);
    chk("R1 funct6 vd kept", res, keep);
    @(negedge clk);
    chk("R1 illegal clears", 128'(illegal), 128'd0);

    // R10 start while busy is ignored
    @(negedge clk);
    insn = mk_insn(6'd0, 1'b1); ew_sel = 2'd0; vl = 5'd16;
    vs1_in = 128'h5; vs2_in = TAB[0].s2; v0_in = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", 128'(busy), 128'd1);
    repeat (2) @(negedge clk);
    insn = mk_insn(6'd3, 1'b1); vs1_in = 128'h77; vs2_in = '1; ew_sel = 2'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 busy start result", vd_out, model(6'd0, 1'b1, 2'd0, 16, 128'h5, TAB[0].s2, 128'h0));
    chk("R10 busy start latency", 128'(lat), 128'd18);
    chk("R10 busy low at done", 128'(busy), 128'd0);

    finish_run();
  end
endmodule